// File: doc/BRIEF.md
# Dual-Channel Boxcar Decimator with Offset-Binary Output

This block turns two single-bit delta-sigma modulator streams into one 16-bit conversion result. One stream comes from the modulator on the positive analog input and the other from the modulator on the negative input. A sequencing controller pulses `start_conv`. The block then counts the ones in each stream over a window of exactly `2**WIN_LOG2` accepted samples. This is a first-order (boxcar) sinc filter, so its first notch sits at the output rate. The block subtracts the negative count from the positive one.

The difference is scaled so that the full span of ones-density, from 0 to 1, covers minus to plus full scale. A bias of 32768 is added to form an offset-binary code, and the code saturates at 0 and at 65535. When the code is ready, `done` pulses for one cycle. The code stays on `code` until the next conversion finishes.

Each conversion is single-shot. Both counts are cleared at the start of a conversion and nothing carries over between windows, so a multiplexed front end sees no latency and no settling. A sample counts only while `sample_en` is high and a conversion is running.

Top module: `dual_sinc1_decim`

## Requirements
- R1: Each channel's count equals the number of ones among exactly N = 2**WIN_LOG2 accepted samples of that channel's stream, where a sample is accepted on a clock edge with `sample_en` high while a conversion is running.
- R2: For counts P (positive) and M (negative), the unclamped code is 32768 + (P − M)·65536/N, with the division carried out as a shift.
- R3: A code that would exceed 65535 (for example, all ones on the positive stream and all zeros on the negative stream) is output as 65535.
- R4: A code that would fall below 0 is output as 0.
- R5: Bit 15 of `code` at `done` is 1 exactly when P ≥ M, and 0 otherwise; P − M = N/4 gives 49152, and P − M = −N/4 gives 16384.
- R6: Clock edges with `sample_en` low change neither count nor the window position, whatever the stream bits are.
- R7: Stream bits presented while no conversion is running, and the bits presented in the cycle that carries `start_conv`, have no effect on the next result; each result depends only on its own window.
- R8: `busy` is high from the edge after `start_conv` until the edge that takes the N-th sample. `done` is low in the cycle after that edge, high for exactly one cycle in the cycle after that, and then low again.
- R9: After reset, `code` is 32768, and `done` and `busy` are low. `code` changes only in a cycle where `done` is high, and it holds its value otherwise.
- R10: A `start_conv` during a running conversion discards the partial window without a `done` pulse and starts a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_conv | input | 1 | One-cycle request to begin a conversion window |
| sample_en | input | 1 | Qualifies the stream bits on this edge as one modulator sample |
| bit_pos | input | 1 | Modulator bit for the positive input |
| bit_neg | input | 1 | Modulator bit for the negative input |
| busy | output | 1 | A conversion window is in progress |
| done | output | 1 | One-cycle pulse: a new code is on `code` |
| code | output | 16 | Offset-binary result, held between conversions |

## Verification
The bench sweeps every pair of counts for a 16-sample window. The span therefore crosses both saturation points, where a missing clamp would wrap, for example to 0 at +FS or to a large code below −FS. It also crosses the sign boundary at P = M, where an off-by-one comparison would flip bit 15. Some sweeps insert idle `sample_en` gaps carrying junk bits, which would shift the counts if a gated edge were counted. One run restarts a half-filled window, which would leak stale ones into the new result if the clear were missing. Junk bits on the start cycle and while idle catch a design that counts outside its window. The timing of `done` and `busy` is checked cycle by cycle on every conversion.

// File: rtl/sinc1_pkg.sv
// Package: shared types for the dual-channel boxcar decimator.
// Assumes: nothing; holds only the sequencing state type.
package sinc1_pkg;

    typedef enum logic {
        CONV_IDLE = 1'b0,
        CONV_RUN  = 1'b1
    } conv_state_e;

endpackage

// File: rtl/sinc1_window_timer.sv
// Window timer: counts accepted modulator samples and closes the window
// after exactly 2**WIN_LOG2 of them.
// Assumes: start_conv is a one-cycle pulse; a start while running restarts
// the window; the sample offered in the start cycle is not accepted.
module sinc1_window_timer
    import sinc1_pkg::*;
#(
    parameter int WIN_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_conv,
    input  logic sample_en,
    output logic busy,
    output logic accept,
    output logic clear,
    output logic win_end
);

    localparam int          CW       = (WIN_LOG2 < 1) ? 1 : WIN_LOG2;
    localparam logic [CW-1:0] LAST_IDX = CW'((1 << WIN_LOG2) - 1);

    conv_state_e   state_q;
    logic [CW-1:0] idx_q;

    // Decode state into the handshake and accumulator controls.
    always_comb begin
        busy   = (state_q == CONV_RUN);
        clear  = start_conv;
        accept = busy && sample_en && !start_conv;
    end

    // Sequence: start, count accepted samples, flag the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CONV_IDLE;
            idx_q   <= '0;
            win_end <= 1'b0;
        end else begin
            win_end <= 1'b0;
            if (start_conv) begin
                state_q <= CONV_RUN;
                idx_q   <= '0;
            end else if (accept) begin
                if (idx_q == LAST_IDX) begin
                    state_q <= CONV_IDLE;
                    idx_q   <= '0;
                    win_end <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // R8: the window-end flag is raised only after the run has stopped.
    assert_end_leaves_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> !busy);

    // R10: a run is entered only from a start request.
    assert_run_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_conv));

    // R6: the sample index moves only on an accepted sample or a start.
    assert_index_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !start_conv) |=> $stable(idx_q));

endmodule

// File: rtl/sinc1_accum.sv
// Boxcar accumulator: counts the ones on one modulator stream within the
// current window.
// Assumes: clear and accept come from the window timer, never both high;
// at most 2**WIN_LOG2 accepts occur between clears.
module sinc1_accum #(
    parameter int WIN_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              accept,
    input  logic              mod_bit,
    output logic [WIN_LOG2:0] ones
);

    localparam logic [WIN_LOG2:0] WIN_LEN = (WIN_LOG2+1)'(1 << WIN_LOG2);

    // Integrate accepted ones; restart at zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones <= '0;
        end else if (clear) begin
            ones <= '0;
        end else if (accept && mod_bit) begin
            ones <= ones + 1'b1;
        end
    end

    // R1: a count never exceeds the window length.
    assert_count_within_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= WIN_LEN);

    // R7: a clear always leaves the count at zero.
    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ones == '0));

endmodule

// File: rtl/sinc1_code_map.sv
// Code mapper: subtracts the two boxcar counts, scales the difference to
// the output code, adds the mid-scale bias, saturates, and holds the result.
// Assumes: the counts are final in the cycle win_end is high.
module sinc1_code_map #(
    parameter int WIN_LOG2 = 10,
    parameter int OUT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_end,
    input  logic [WIN_LOG2:0] cnt_pos,
    input  logic [WIN_LOG2:0] cnt_neg,
    output logic              done,
    output logic [OUT_W-1:0]  code
);

    localparam int CW = WIN_LOG2 + 1;
    localparam int SW = ((OUT_W > WIN_LOG2) ? OUT_W : WIN_LOG2) + 3;
    localparam logic signed [SW-1:0] BIAS     = SW'(1 << (OUT_W - 1));
    localparam logic signed [SW-1:0] CODE_MAX = SW'((1 << OUT_W) - 1);
    localparam logic [OUT_W-1:0]     MID_CODE = OUT_W'(1 << (OUT_W - 1));

    logic signed [CW:0]      diff;
    logic signed [SW-1:0]    diff_ext;
    logic signed [SW-1:0]    scaled;
    logic signed [SW-1:0]    biased;
    logic        [OUT_W-1:0] code_next;

    // Signed difference of the two counts, widened for scaling.
    always_comb begin
        diff     = $signed({1'b0, cnt_pos}) - $signed({1'b0, cnt_neg});
        diff_ext = {{(SW - CW - 1){diff[CW]}}, diff};
    end

    // Scale by the ratio of code span to window length (a pure shift).
    generate
        if (WIN_LOG2 <= OUT_W) begin : g_scale_up
            assign scaled = diff_ext <<< (OUT_W - WIN_LOG2);
        end else begin : g_scale_down
            assign scaled = diff_ext >>> (WIN_LOG2 - OUT_W);
        end
    endgenerate

    // Bias to offset binary and saturate at both ends.
    always_comb begin
        biased = scaled + BIAS;
        if (biased < 0) begin
            code_next = '0;
        end else if (biased > CODE_MAX) begin
            code_next = '1;
        end else begin
            code_next = biased[OUT_W-1:0];
        end
    end

    // Capture the result on window end and raise done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            code <= MID_CODE;
        end else begin
            done <= win_end;
            if (win_end) begin
                code <= code_next;
            end
        end
    end

    // R8: done is a single-cycle pulse.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the held code moves only when done reports it.
    assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(code));

    // R3: a positive-over-full-scale difference reports the top code.
    assert_clamp_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && (scaled >= BIAS)) |=> (code == '1));

    // R4: a negative-over-full-scale difference reports code zero.
    assert_clamp_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && (scaled <= -BIAS)) |=> (code == '0));

endmodule

// File: rtl/dual_sinc1_decim.sv
// Top: dual-channel boxcar decimator. Two modulator streams are counted
// over one shared window; the difference becomes an offset-binary code.
// Assumes: both modulators are sampled on the same sample_en strobe; the
// controller waits for done (or restarts) before expecting a new result.
module dual_sinc1_decim #(
    parameter int WIN_LOG2 = 10,
    parameter int OUT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_conv,
    input  logic             sample_en,
    input  logic             bit_pos,
    input  logic             bit_neg,
    output logic             busy,
    output logic             done,
    output logic [OUT_W-1:0] code
);

    localparam int NCH = 2;

    logic              accept;
    logic              clear;
    logic              win_end;
    logic [NCH-1:0]    ch_bit;
    logic [WIN_LOG2:0] ch_cnt [NCH];

    assign ch_bit = {bit_neg, bit_pos};

    sinc1_window_timer #(
        .WIN_LOG2 (WIN_LOG2)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_conv (start_conv),
        .sample_en  (sample_en),
        .busy       (busy),
        .accept     (accept),
        .clear      (clear),
        .win_end    (win_end)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
            sinc1_accum #(
                .WIN_LOG2 (WIN_LOG2)
            ) i_accum (
                .clk     (clk),
                .rst_n   (rst_n),
                .clear   (clear),
                .accept  (accept),
                .mod_bit (ch_bit[ch]),
                .ones    (ch_cnt[ch])
            );
        end
    endgenerate

    sinc1_code_map #(
        .WIN_LOG2 (WIN_LOG2),
        .OUT_W    (OUT_W)
    ) i_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_end (win_end),
        .cnt_pos (ch_cnt[0]),
        .cnt_neg (ch_cnt[1]),
        .done    (done),
        .code    (code)
    );

    // R5: the sign bit follows the comparison of the final counts.
    assert_sign_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (code[OUT_W-1] == ($past(ch_cnt[0]) >= $past(ch_cnt[1]))));

    // R8: done never appears while a window is still running.
    assert_done_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!busy));

endmodule

// File: tb/test_dual_sinc1_decim.sv
// Bench: exhaustive count-pair sweep on a 16-sample window, plus gap,
// idle, restart and timing checks, all against arithmetic expectations.
module test_dual_sinc1_decim;

    localparam int WL  = 4;
    localparam int NW  = 1 << WL;
    localparam int OW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_conv = 1'b0;
    logic          sample_en = 1'b0;
    logic          bit_pos = 1'b0;
    logic          bit_neg = 1'b0;
    logic          busy;
    logic          done;
    logic [OW-1:0] code;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    dual_sinc1_decim #(.WIN_LOG2(WL), .OUT_W(OW)) i_dual_sinc1_decim (
        .clk(clk), .rst_n(rst_n), .start_conv(start_conv), .sample_en(sample_en),
        .bit_pos(bit_pos), .bit_neg(bit_neg), .busy(busy), .done(done), .code(code)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int p, input int m);
        int v;
        v = 32768 + (p - m) * (65536 / NW);
        if (v > 65535) v = 65535;
        if (v < 0) v = 0;
        return v;
    endfunction

    // Run one conversion with P ones on the positive stream and M on the negative.
    task automatic run_conv(input int p, input int m, input bit gaps, input bit late);
        int e;
        @(negedge clk);
        start_conv = 1'b1; sample_en = 1'b1; bit_pos = 1'b1; bit_neg = 1'b1;
        @(negedge clk);
        start_conv = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        for (int i = 0; i < NW; i++) begin
            if (gaps && (i % 3 == 1)) begin
                sample_en = 1'b0; bit_pos = 1'b1; bit_neg = 1'b0;   // R6 junk
                @(negedge clk);
            end
            sample_en = 1'b1;
            bit_pos = late ? (i >= NW - p) : (i < p);
            bit_neg = (((i * 7) % NW) < m);
            @(negedge clk);
        end
        sample_en = 1'b0; bit_pos = 1'b0; bit_neg = 1'b0;
        chk(done == 1'b0, "R8 done low one cycle after last sample", done, 0);
        chk(busy == 1'b0, "R8 busy low after last sample", busy, 0);
        @(negedge clk);
        e = exp_code(p, m);
        chk(done == 1'b1, "R8 done pulse", done, 1);
        if (p - m >= NW / 2)       chk(code == e, "R3 clamp high", code, e);
        else if (m - p >= NW / 2)  chk(code == e, "R4 clamp low", code, e);
        else                       chk(code == e, gaps ? "R6 gapped code" : "R2 code", code, e);
        chk(code[15] == (p >= m), "R5 sign bit", code[15], (p >= m));
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", done, 0);
        chk(code == e, "R9 code held", code, e);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(code == 32768, "R9 reset code", code, 32768);
        chk(done == 1'b0, "R9 reset done", done, 0);
        chk(busy == 1'b0, "R9 reset busy", busy, 0);

        // R1 R2 R3 R4 R5: every count pair
        for (int p = 0; p <= NW; p++) begin
            for (int m = 0; m <= NW; m++) begin
                run_conv(p, m, 1'b0, (p % 2) == 1);
            end
        end

        // R6: idle sample_en gaps with junk bits
        run_conv(12, 8, 1'b1, 1'b0);   // +N/4 -> 49152
        run_conv(4, 8, 1'b1, 1'b1);    // -N/4 -> 16384
        run_conv(9, 9, 1'b1, 1'b0);
        run_conv(NW, 0, 1'b1, 1'b0);

        // R7: stream activity with no conversion running is ignored
        for (int k = 0; k < 20; k++) begin
            sample_en = 1'b1; bit_pos = 1'b1; bit_neg = 1'b0;
            @(negedge clk);
            chk(done == 1'b0, "R7 no done while idle", done, 0);
        end
        chk(code == exp_code(NW, 0), "R7 code unchanged while idle", code, exp_code(NW, 0));
        sample_en = 1'b0;
        run_conv(3, 5, 1'b0, 1'b0);

        // R10: restart a half-filled window with stale ones
        @(negedge clk);
        start_conv = 1'b1;
        @(negedge clk);
        start_conv = 1'b0;
        for (int k = 0; k < 7; k++) begin
            sample_en = 1'b1; bit_pos = 1'b1; bit_neg = 1'b0;
            @(negedge clk);
            chk(done == 1'b0, "R10 no done for aborted window", done, 0);
        end
        run_conv(2, 2, 1'b0, 1'b0);
        run_conv(2, 5, 1'b0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule